// File: doc/BRIEF.md
# PHY link configuration sequencer

This block runs once per `start` pulse and, acting as master on a simple register bus, forces an attached Ethernet PHY into fixed 100 Mbit full-duplex operation. It first confirms that the bridge device behind the bus answers with the expected identification pattern and reports itself ready, trying again a bounded number of times if it does not. It then claims PHY management access from the network side and reads the PHY's basic control register (index 0) through a management window of address, index, data and control/status registers.

When the control value already has full duplex and 100 Mbit selected with autonegotiation off, it is left alone. Otherwise the sequencer clears autonegotiation, sets the two mode bits and writes the value back through the same window. Each window command is polled until its busy flag drops, and an error flag or a poll timeout aborts the operation. Whenever ownership was claimed, it is handed back as the last bus access, also after an error, and a one-cycle completion pulse then reports the outcome.

Top module: `phy_link_cfg_seq`

## Requirements
- R1: An attempt succeeds only if a read of address 0x0064 returns 0x87654321 and a following read of address 0x0074 returns a word with bit 27 set. A failed identification read skips the readiness read.
- R2: A failed attempt is repeated from the identification read. After NUM_TRIES (default 10) failed attempts the sequence ends with an error, and no write to the ownership register at 0x0517 takes place.
- R3: After a successful attempt, 0x01 is written to 0x0517 before any access to addresses 0x0510 to 0x0514. Once ownership is taken, the last bus access of the sequence writes 0x00 to 0x0517, with or without an error, and this happens before the completion pulse.
- R4: A PHY read writes PHY_ADDR to 0x0512 and the index 0 to 0x0513. It then writes 0x0100 to the control register 0x0510, polls 0x0510, and takes the 16-bit value from 0x0514.
- R5: A PHY write loads 0x0512, 0x0513 and the new value into 0x0514 before it writes 0x0200 to 0x0510, and then polls 0x0510 in the same way.
- R6: A poll read of 0x0510 with bit 14 (command error) or bit 13 (read error) set ends the operation with an error at once, even if bit 15 (busy) is also set. A read with all three bits clear completes the command.
- R7: A poll read that still shows busy after TIMEOUT_CYC or more cycles since the command write completed ends the operation with an error. Busy that clears earlier causes no error.
- R8: A control value with bit 8 set, bit 13 set and bit 12 clear is not written back. Any other value v is written back as v with bit 12 cleared and bits 8 and 13 set, leaving all other bits as read.
- R9: `cfg_done` is a one-cycle pulse at the end of every sequence. `cfg_err` and `cfg_changed` are only high together with `cfg_done`. `cfg_changed` is high exactly when a write-back completed without error.
- R10: `bus_req` stays high, with address, direction and write data stable, until a cycle in which `bus_ack` is high. It is low in the following cycle. `bus_rdata` is taken in the acknowledging cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (accepted while idle) |
| cfg_done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Sequence failed, valid with cfg_done |
| cfg_changed | output | 1 | Control register was rewritten, valid with cfg_done |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Completes the pending request |

## Verification
The bench runs the sequence against a behavioural bridge model and uses several kinds of PHY control values. It tries the already-correct value, values that differ in only one of the three mode bits, the all-zero and all-one extremes, and random words. Together these show whether the keep decision tests each bit on its own and whether the rewrite leaves unrelated bits alone. Identification patterns that fail a few times and then pass, or never pass, together with a device that never becomes ready, separate retry counting from the final error path. Busy that clears within the limit, busy that never clears, and each error flag raised together with busy show apart a completion, a timeout and an abort, and each abort must still end with the ownership release.

// File: rtl/phy_link_cfg_pkg.sv
package phy_link_cfg_pkg;

  localparam int BUS_AW = 16;
  localparam int BUS_DW = 32;

  // register map of the bridge seen through the bus
  localparam logic [BUS_AW-1:0] ADR_IDENT  = 16'h0064;
  localparam logic [BUS_AW-1:0] ADR_HWSTAT = 16'h0074;
  localparam logic [BUS_AW-1:0] ADR_MCTL   = 16'h0510;
  localparam logic [BUS_AW-1:0] ADR_MPHY   = 16'h0512;
  localparam logic [BUS_AW-1:0] ADR_MIDX   = 16'h0513;
  localparam logic [BUS_AW-1:0] ADR_MDATA  = 16'h0514;
  localparam logic [BUS_AW-1:0] ADR_OWNER  = 16'h0517;

  localparam logic [BUS_DW-1:0] IDENT_WORD = 32'h8765_4321;
  localparam int HW_READY_BIT = 27;

  localparam int MCTL_BUSY = 15;
  localparam int MCTL_CERR = 14;
  localparam int MCTL_RERR = 13;
  localparam logic [15:0] MCMD_READ  = 16'h0100;
  localparam logic [15:0] MCMD_WRITE = 16'h0200;

  // PHY basic control register fields
  localparam int PCR_DUPLEX = 8;
  localparam int PCR_AUTONEG = 12;
  localparam int PCR_SPEED = 13;
  localparam logic [4:0] PCR_INDEX = 5'd0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_IDENT, ST_RD_HW, ST_TAKE, ST_SET_PHY, ST_SET_IDX,
    ST_SET_DATA, ST_CMD, ST_POLL, ST_RD_DATA, ST_RELEASE, ST_FINISH
  } seq_state_t;

  function automatic logic ident_good(input logic [BUS_DW-1:0] w);
    return w == IDENT_WORD;
  endfunction

  function automatic logic hw_ready(input logic [BUS_DW-1:0] w);
    return w[HW_READY_BIT];
  endfunction

  function automatic logic mctl_fault(input logic [BUS_DW-1:0] w);
    return w[MCTL_CERR] | w[MCTL_RERR];
  endfunction

  function automatic logic mctl_busy(input logic [BUS_DW-1:0] w);
    return w[MCTL_BUSY];
  endfunction

  function automatic logic pcr_in_mode(input logic [15:0] v);
    return v[PCR_DUPLEX] & v[PCR_SPEED] & ~v[PCR_AUTONEG];
  endfunction

  function automatic logic [15:0] pcr_forced(input logic [15:0] v);
    logic [15:0] r;
    r = v;
    r[PCR_AUTONEG] = 1'b0;
    r[PCR_DUPLEX]  = 1'b1;
    r[PCR_SPEED]   = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/plc_bus_agent.sv
module plc_bus_agent
  import phy_link_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              op_we,
  input  logic [BUS_AW-1:0] op_addr,
  input  logic [BUS_DW-1:0] op_wdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [BUS_DW-1:0] bus_rdata,
  output logic              txn_done,
  output logic [BUS_DW-1:0] txn_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      txn_done  <= 1'b0;
      txn_rdata <= '0;
    end else begin
      txn_done <= 1'b0;
      if (bus_req && bus_ack) begin
        bus_req   <= 1'b0;
        txn_done  <= 1'b1;
        txn_rdata <= bus_rdata;
      end else if (launch && !bus_req) begin
        bus_req   <= 1'b1;
        bus_we    <= op_we;
        bus_addr  <= op_addr;
        bus_wdata <= op_wdata;
      end
    end
  end

endmodule

// File: rtl/plc_poll_timer.sv
module plc_poll_timer #(
  parameter int TIMEOUT_CYC = 62500,
  localparam int TW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic en,
  output logic expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (en && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt >= TW'(TIMEOUT_CYC));

endmodule

// File: rtl/plc_fsm.sv
module plc_fsm
  import phy_link_cfg_pkg::*;
#(
  parameter int PHY_ADDR = 1,
  parameter int NUM_TRIES = 10,
  localparam int NW = $clog2(NUM_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              txn_done,
  input  logic [BUS_DW-1:0] txn_rdata,
  input  logic              tmr_expired,
  output logic              launch,
  output logic              op_we,
  output logic [BUS_AW-1:0] op_addr,
  output logic [BUS_DW-1:0] op_wdata,
  output logic              tmr_clear,
  output logic              tmr_en,
  output logic              own_held,
  output logic              poll_fault,
  output logic              poll_timeout,
  output logic [NW-1:0]     tries,
  output seq_state_t        state,
  output logic              cfg_done,
  output logic              cfg_err,
  output logic              cfg_changed
);

  logic        inflight;
  logic        op_bus;
  logic        wb_pass;
  logic        err_q;
  logic        chg_q;
  logic [15:0] new_val;
  logic        attempt_fail;
  logic        poll_clear;

  always_comb begin
    op_bus   = 1'b1;
    op_we    = 1'b1;
    op_addr  = ADR_OWNER;
    op_wdata = '0;
    unique case (state)
      ST_RD_IDENT: begin op_we = 1'b0; op_addr = ADR_IDENT; end
      ST_RD_HW:    begin op_we = 1'b0; op_addr = ADR_HWSTAT; end
      ST_TAKE:     begin op_addr = ADR_OWNER; op_wdata = 32'h1; end
      ST_SET_PHY:  begin op_addr = ADR_MPHY; op_wdata = BUS_DW'(PHY_ADDR); end
      ST_SET_IDX:  begin op_addr = ADR_MIDX; op_wdata = BUS_DW'(PCR_INDEX); end
      ST_SET_DATA: begin op_addr = ADR_MDATA; op_wdata = BUS_DW'(new_val); end
      ST_CMD: begin
        op_addr  = ADR_MCTL;
        op_wdata = BUS_DW'(wb_pass ? MCMD_WRITE : MCMD_READ);
      end
      ST_POLL:     begin op_we = 1'b0; op_addr = ADR_MCTL; end
      ST_RD_DATA:  begin op_we = 1'b0; op_addr = ADR_MDATA; end
      ST_RELEASE:  begin op_addr = ADR_OWNER; op_wdata = '0; end
      default:     op_bus = 1'b0;
    endcase
  end

  assign launch = op_bus && !inflight;

  // events named for the checker
  assign attempt_fail = txn_done &&
                        ((state == ST_RD_IDENT && !ident_good(txn_rdata)) ||
                         (state == ST_RD_HW && !hw_ready(txn_rdata)));
  assign poll_fault   = txn_done && (state == ST_POLL) && mctl_fault(txn_rdata);
  assign poll_clear   = txn_done && (state == ST_POLL) && !mctl_fault(txn_rdata)
                        && !mctl_busy(txn_rdata);
  assign poll_timeout = txn_done && (state == ST_POLL) && !mctl_fault(txn_rdata)
                        && mctl_busy(txn_rdata) && tmr_expired;
  assign tmr_clear    = txn_done && (state == ST_CMD);
  assign tmr_en       = (state == ST_POLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      inflight    <= 1'b0;
      wb_pass     <= 1'b0;
      err_q       <= 1'b0;
      chg_q       <= 1'b0;
      new_val     <= '0;
      tries       <= '0;
      own_held    <= 1'b0;
      cfg_done    <= 1'b0;
      cfg_err     <= 1'b0;
      cfg_changed <= 1'b0;
    end else begin
      cfg_done    <= 1'b0;
      cfg_err     <= 1'b0;
      cfg_changed <= 1'b0;
      if (launch) inflight <= 1'b1;
      if (txn_done) inflight <= 1'b0;

      if (attempt_fail) begin
        if (tries == NW'(NUM_TRIES - 1)) begin
          err_q <= 1'b1;
          state <= ST_FINISH;
        end else begin
          tries <= tries + 1'b1;
          state <= ST_RD_IDENT;
        end
      end else begin
        unique case (state)
          ST_IDLE: if (start) begin
            tries   <= '0;
            err_q   <= 1'b0;
            chg_q   <= 1'b0;
            wb_pass <= 1'b0;
            state   <= ST_RD_IDENT;
          end
          ST_RD_IDENT: if (txn_done) state <= ST_RD_HW;
          ST_RD_HW:    if (txn_done) state <= ST_TAKE;
          ST_TAKE: if (txn_done) begin
            own_held <= 1'b1;
            state    <= ST_SET_PHY;
          end
          ST_SET_PHY: if (txn_done) state <= ST_SET_IDX;
          ST_SET_IDX: if (txn_done) state <= wb_pass ? ST_SET_DATA : ST_CMD;
          ST_SET_DATA: if (txn_done) state <= ST_CMD;
          ST_CMD: if (txn_done) state <= ST_POLL;
          ST_POLL: begin
            if (poll_fault || poll_timeout) begin
              err_q <= 1'b1;
              state <= ST_RELEASE;
            end else if (poll_clear) begin
              if (wb_pass) begin
                chg_q <= 1'b1;
                state <= ST_RELEASE;
              end else begin
                state <= ST_RD_DATA;
              end
            end
          end
          ST_RD_DATA: if (txn_done) begin
            if (pcr_in_mode(txn_rdata[15:0])) begin
              state <= ST_RELEASE;
            end else begin
              new_val <= pcr_forced(txn_rdata[15:0]);
              wb_pass <= 1'b1;
              state   <= ST_SET_PHY;
            end
          end
          ST_RELEASE: if (txn_done) begin
            own_held <= 1'b0;
            state    <= ST_FINISH;
          end
          ST_FINISH: begin
            cfg_done    <= 1'b1;
            cfg_err     <= err_q;
            cfg_changed <= chg_q && !err_q;
            state       <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/phy_link_cfg_seq.sv
module phy_link_cfg_seq
  import phy_link_cfg_pkg::*;
#(
  parameter int PHY_ADDR = 1,
  parameter int TIMEOUT_CYC = 62500,
  parameter int NUM_TRIES = 10,
  localparam int NW = $clog2(NUM_TRIES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        cfg_done,
  output logic        cfg_err,
  output logic        cfg_changed,
  output logic        bus_req,
  output logic        bus_we,
  output logic [15:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_ack
);

  logic              launch;
  logic              op_we;
  logic [BUS_AW-1:0] op_addr;
  logic [BUS_DW-1:0] op_wdata;
  logic              txn_done;
  logic [BUS_DW-1:0] txn_rdata;
  logic              tmr_clear;
  logic              tmr_en;
  logic              tmr_expired;
  logic              own_held;
  logic              poll_fault;
  logic              poll_timeout;
  logic [NW-1:0]     tries;
  seq_state_t        state;

  plc_bus_agent u_agent (
    .clk(clk), .rst_n(rst_n), .launch(launch), .op_we(op_we),
    .op_addr(op_addr), .op_wdata(op_wdata), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .txn_done(txn_done),
    .txn_rdata(txn_rdata)
  );

  plc_poll_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .en(tmr_en),
    .expired(tmr_expired)
  );

  plc_fsm #(.PHY_ADDR(PHY_ADDR), .NUM_TRIES(NUM_TRIES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .txn_done(txn_done),
    .txn_rdata(txn_rdata), .tmr_expired(tmr_expired), .launch(launch),
    .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata),
    .tmr_clear(tmr_clear), .tmr_en(tmr_en), .own_held(own_held),
    .poll_fault(poll_fault), .poll_timeout(poll_timeout), .tries(tries),
    .state(state), .cfg_done(cfg_done), .cfg_err(cfg_err),
    .cfg_changed(cfg_changed)
  );

endmodule

// File: rtl/phy_link_cfg_chk.sv
module phy_link_cfg_chk
  import phy_link_cfg_pkg::*;
#(
  parameter int NUM_TRIES = 10,
  localparam int NW = $clog2(NUM_TRIES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_done,
  input logic              cfg_err,
  input logic              cfg_changed,
  input logic              bus_req,
  input logic              bus_we,
  input logic [15:0]       bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic              own_held,
  input logic              poll_fault,
  input logic              poll_timeout,
  input logic [NW-1:0]     tries,
  input seq_state_t        state
);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_wdata)));

  assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack) |=> !bus_req);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> !cfg_done);

  assert_flags_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err || cfg_changed) |-> cfg_done);

  assert_changed_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_changed |-> !cfg_err);

  assert_window_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_addr >= ADR_MCTL && bus_addr <= ADR_MDATA) |-> own_held);

  assert_release_before_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !own_held);

  assert_fault_aborts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_fault |=> (state == ST_RELEASE));

  assert_timeout_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_timeout |=> (state == ST_RELEASE));

  assert_tries_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tries < NW'(NUM_TRIES));

endmodule

bind phy_link_cfg_seq phy_link_cfg_chk #(.NUM_TRIES(NUM_TRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .cfg_err(cfg_err),
  .cfg_changed(cfg_changed), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .own_held(own_held), .poll_fault(poll_fault), .poll_timeout(poll_timeout),
  .tries(tries), .state(state)
);

// File: tb/phy_link_cfg_seq_bench.sv
module phy_link_cfg_seq_bench;

  localparam int PHY = 3;
  localparam int TMO = 300;
  localparam int TRIES = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        cfg_done, cfg_err, cfg_changed;
  logic        bus_req, bus_we;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;

  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  phy_link_cfg_seq #(.PHY_ADDR(PHY), .TIMEOUT_CYC(TMO), .NUM_TRIES(TRIES))
    u_phy_link_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_done(cfg_done),
    .cfg_err(cfg_err), .cfg_changed(cfg_changed), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  // ---------------- bridge model ----------------
  logic [15:0] m_pcr;
  logic [7:0]  m_own;
  logic [7:0]  m_phy, m_idx;
  logic [15:0] m_dat;
  bit          m_dat_loaded;
  int          m_busy_cfg;   // polls reporting busy per command, -1 = forever
  int          m_busy_left;
  int          m_fault;      // 0 none, 1 command error, 2 read error
  int          m_id_bad;
  bit          m_ready;
  int          c_id_reads, c_own_writes, c_order_bad, c_wcmds;
  logic [15:0] last_addr;
  logic [31:0] last_wdata;
  bit          last_we;
  int          lat = 0;

  task automatic serve();
    last_addr = bus_addr; last_wdata = bus_wdata; last_we = bus_we;
    bus_rdata = '0;
    if (bus_we) begin
      case (bus_addr)
        16'h0517: begin m_own = bus_wdata[7:0]; c_own_writes++; end
        16'h0512: m_phy = bus_wdata[7:0];
        16'h0513: m_idx = bus_wdata[7:0];
        16'h0514: begin m_dat = bus_wdata[15:0]; m_dat_loaded = 1; end
        16'h0510: begin
          if (m_own != 8'h01 || m_phy != 8'(PHY) || m_idx != 8'h00) c_order_bad++;
          if (bus_wdata == 32'h0100) m_dat = m_pcr;
          else if (bus_wdata == 32'h0200) begin
            if (!m_dat_loaded) c_order_bad++;
            m_pcr = m_dat; c_wcmds++;
          end else c_order_bad++;
          m_dat_loaded = 0;
          m_busy_left = m_busy_cfg;
        end
        default: c_order_bad++;
      endcase
    end else begin
      case (bus_addr)
        16'h0064: begin
          c_id_reads++;
          if (m_id_bad > 0) begin m_id_bad--; bus_rdata = 32'h1234_5678; end
          else bus_rdata = 32'h8765_4321;
        end
        16'h0074: bus_rdata = m_ready ? 32'h0800_0005 : 32'h0000_0005;
        16'h0510: begin
          if (m_own != 8'h01) c_order_bad++;
          if (m_busy_left != 0) begin
            bus_rdata[15] = 1'b1;
            if (m_busy_left > 0) m_busy_left--;
          end
          if (m_fault == 1) begin bus_rdata[14] = 1'b1; bus_rdata[15] = 1'b1; end
          if (m_fault == 2) begin bus_rdata[13] = 1'b1; bus_rdata[15] = 1'b1; end
        end
        16'h0514: begin
          if (m_own != 8'h01) c_order_bad++;
          bus_rdata = {16'h0, m_dat};
        end
        default: c_order_bad++;
      endcase
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
        if (lat == 0) begin
          serve();
          bus_ack = 1'b1;
          lat = int'($urandom % 4);
        end else lat--;
      end
    end
  end

  // ---------------- bench reference ----------------
  function automatic bit want_keep(input logic [15:0] v);
    return (v[8] == 1'b1) && (v[13] == 1'b1) && (v[12] == 1'b0);
  endfunction

  function automatic logic [15:0] want_value(input logic [15:0] v);
    return (v | 16'h2100) & 16'hEFFF;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input logic [15:0] init, input int id_bad,
                          input bit ready, input int busy, input int fault);
    bit got_done, e, c, good, abort;
    int waited;
    m_pcr = init; m_own = 8'h00; m_phy = 8'hFF; m_idx = 8'hFF; m_dat = '0;
    m_dat_loaded = 0; m_busy_cfg = busy; m_busy_left = 0; m_fault = fault;
    m_id_bad = id_bad; m_ready = ready;
    c_id_reads = 0; c_own_writes = 0; c_order_bad = 0; c_wcmds = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    got_done = 0; waited = 0;
    while (!got_done && waited < 20000) begin
      if (cfg_done) got_done = 1;
      else begin @(negedge clk); waited++; end
    end
    check(got_done, "R9", "done seen", 32'(got_done), 32'd1);
    if (!got_done) return;
    e = cfg_err; c = cfg_changed;
    @(negedge clk);
    check(!cfg_done && !cfg_err && !cfg_changed, "R9", "single-cycle done",
          {cfg_done, cfg_err, cfg_changed}, 32'd0);

    good = (id_bad < TRIES) && ready;
    abort = (fault != 0) || (busy < 0);
    check(c_order_bad == 0, "R4", "window order/ownership (R5, R3)", c_order_bad, 0);
    if (!good) begin
      check(e == 1'b1, "R2", "error after all tries", e, 1);
      check(c_id_reads == TRIES, "R2", "identification reads", c_id_reads, TRIES);
      check(c_own_writes == 0, "R2", "no ownership write", c_own_writes, 0);
      check(c == 1'b0, "R9", "no change flag", c, 0);
    end else begin
      check(c_id_reads == id_bad + 1, "R1", "identification reads", c_id_reads, id_bad + 1);
      check(c_own_writes == 2 && m_own == 8'h00, "R3", "take+release count",
            c_own_writes, 2);
      check(last_we && last_addr == 16'h0517 && last_wdata == 0, "R3",
            "release is last access", {last_addr, last_wdata[15:0]}, 32'h05170000);
      if (abort) begin
        check(e == 1'b1, fault != 0 ? "R6" : "R7", "abort error", e, 1);
        check(c == 1'b0, "R9", "no change on abort", c, 0);
        check(m_pcr == init, "R6", "register untouched on abort", m_pcr, init);
      end else begin
        check(e == 1'b0, "R7", "no error", e, 0);
        check(c == !want_keep(init), "R8", "changed flag", c, !want_keep(init));
        check(m_pcr == (want_keep(init) ? init : want_value(init)), "R8",
              "final control value", m_pcr,
              want_keep(init) ? init : want_value(init));
        check(c_wcmds == (want_keep(init) ? 0 : 1), "R5", "write commands",
              c_wcmds, want_keep(init) ? 0 : 1);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!cfg_done && !cfg_err && !cfg_changed, "R9", "reset outputs",
          {cfg_done, cfg_err, cfg_changed}, 0);
    check(!bus_req, "R10", "reset request", bus_req, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed control values (R8)
    run_case(16'h2100, 0, 1, 0, 0);
    run_case(16'h3100, 0, 1, 1, 0);
    run_case(16'h2000, 0, 1, 0, 0);
    run_case(16'h0100, 0, 1, 2, 0);
    run_case(16'h0000, 0, 1, 0, 0);
    run_case(16'hFFFF, 0, 1, 3, 0);
    run_case(16'hDEFF, 0, 1, 0, 0);
    // retries (R1, R2)
    run_case(16'h1000, 4, 1, 0, 0);
    run_case(16'h1000, TRIES - 1, 1, 0, 0);
    run_case(16'h1000, TRIES, 1, 0, 0);
    run_case(16'h1000, 0, 0, 0, 0);
    // aborts (R6, R7) and slow busy within limit
    run_case(16'h0000, 0, 1, 2, 1);
    run_case(16'h0000, 0, 1, 2, 2);
    run_case(16'h0000, 0, 1, -1, 0);
    run_case(16'h0000, 0, 1, 12, 0);
    // random control values, random busy
    for (int i = 0; i < 24; i++) begin
      run_case(16'($urandom), int'($urandom % 3), 1, int'($urandom % 8), 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule